// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block produces the word address for a synchronous burst memory. On a rising clock edge it captures an external address, together with the combined state of three chip enables, whenever one of two active-low address strobes is asserted. On later cycles an active-low advance input steps a two-bit burst count. The low two address bits are formed from the loaded low bits and that count. The upper bits stay where they were loaded.

A static, unclocked order input selects the burst sequence. In linear order the low bits count upward from the loaded value and wrap modulo 4. In interleaved order they are the loaded value XORed with the count. The registered select flag records whether the device was enabled at the most recent accepted load.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low and after its release, addr_o is all zeros and sel_o is 0 until the first load.
- R2: When ctrl_stb_ni is 0 at a rising edge, the block loads addr_i and clears the count to 0. sel_o becomes 1 only if ce1_ni=0, ce2_i=1 and ce3_ni=0 at that edge, and 0 otherwise. This happens whatever proc_stb_ni and adv_ni are.
- R3: When ctrl_stb_ni is 1, proc_stb_ni is 0 and all three enables are active, the block loads addr_i, clears the count and sets sel_o to 1.
- R4: When ctrl_stb_ni is 1, proc_stb_ni is 0 and any enable is inactive, the processor strobe is ignored. The edge then behaves as an advance if adv_ni is 0, and as a hold otherwise; sel_o and the upper address are left unchanged.
- R5: A load (R2 or R3) takes priority over advance: after a load with adv_ni=0, the count is 0 and addr_o equals addr_i.
- R6: With order_i=0 (linear), addr_o[1:0] equals the loaded low bits plus the count, modulo 4.
- R7: With order_i=1 (interleaved), addr_o[1:0] equals the loaded low bits XOR the count.
- R8: addr_o above bit 1 changes only on a load; the two-bit count never carries into it.
- R9: When adv_ni is 0 and no load occurs, the count increments modulo 4, so four advances return addr_o to its loaded value.
- R10: When no load occurs and adv_ni is 1, addr_o and sel_o hold.
- R11: order_i is not clocked: changing it changes addr_o[1:0] without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address captured on a load |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low, always loads |
| proc_stb_ni | input | 1 | Processor address strobe, active low, loads only when enabled |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst word address |
| sel_o | output | 1 | Registered device-select flag |

## Verification
Every start value of the low bits is loaded under both orders with three upper patterns: all zeros, all ones and alternating. Each is followed by a run of advances long enough to wrap twice. These runs separate the linear and interleaved sequences and expose any carry into the upper bits, most visibly with all ones. All eight chip-enable combinations are applied under each strobe. This tells the unconditional controller load apart from the gated processor load, and shows where an ignored processor strobe falls through to advance or hold. Cycles with both strobes low, or with a strobe and advance together, confirm the priority order. Toggling the order input between edges shows that it acts without a clock.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned CNT_W = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    ACT_HOLD      = 2'd0,
    ACT_ADVANCE   = 2'd1,
    ACT_LOAD_CTRL = 2'd2,
    ACT_LOAD_PROC = 2'd3
  } burst_act_e;

  function automatic logic [CNT_W-1:0] burst_low(input burst_order_e order,
                                                 input logic [CNT_W-1:0] start,
                                                 input logic [CNT_W-1:0] cnt);
    if (order == ORDER_INTERLEAVE) return start ^ cnt;
    return CNT_W'(start + cnt);
  endfunction
endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
(
  input  logic       ctrl_stb_ni,
  input  logic       proc_stb_ni,
  input  logic       adv_ni,
  input  logic       ce1_ni,
  input  logic       ce2_i,
  input  logic       ce3_ni,
  output burst_act_e act_o,
  output logic       sel_d_o
);
  logic ce_ok;

  assign ce_ok = ~ce1_ni & ce2_i & ~ce3_ni;

  always_comb begin
    sel_d_o = ce_ok;
    if (!ctrl_stb_ni)               act_o = ACT_LOAD_CTRL;
    else if (!proc_stb_ni && ce_ok) act_o = ACT_LOAD_PROC;
    else if (!adv_ni)               act_o = ACT_ADVANCE;
    else                            act_o = ACT_HOLD;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= CNT_W'(cnt_q + 1'b1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R5
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o)); // R10
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_d_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              sel_o
);
  logic [ADDR_W-1:0] base_q;
  logic              sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      sel_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= addr_i;
      sel_q  <= sel_d_i;
    end
  end

  assign base_o = base_q;
  assign sel_o  = sel_q;

  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o)); // R8
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sel_o)); // R10
endmodule

// File: rtl/burst_order_mux.sv
module burst_order_mux
  import burst_pkg::*;
#(
  parameter int unsigned LO_W = CNT_W
) (
  input  burst_order_e    order_i,
  input  logic [LO_W-1:0] start_i,
  input  logic [LO_W-1:0] cnt_i,
  output logic [LO_W-1:0] lo_o
);
  logic [LO_W-1:0] lin, ilv;

  assign lin = LO_W'(start_i + cnt_i);

  for (genvar b = 0; b < LO_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ cnt_i[b];
  end

  assign lo_o = (order_i == ORDER_INTERLEAVE) ? ilv : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ctrl_stb_ni,
  input  logic              proc_stb_ni,
  input  logic              adv_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  burst_act_e        act;
  logic              sel_d, load, inc;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  cnt, lo;
  burst_order_e      order;

  assign order = burst_order_e'(order_i);

  burst_decode u_decode (
    .ctrl_stb_ni (ctrl_stb_ni),
    .proc_stb_ni (proc_stb_ni),
    .adv_ni      (adv_ni),
    .ce1_ni      (ce1_ni),
    .ce2_i       (ce2_i),
    .ce3_ni      (ce3_ni),
    .act_o       (act),
    .sel_d_o     (sel_d)
  );

  assign load = (act == ACT_LOAD_CTRL) || (act == ACT_LOAD_PROC);
  assign inc  = (act == ACT_ADVANCE);

  burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .inc_i  (inc),
    .cnt_o  (cnt)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .sel_d_i (sel_d),
    .base_o  (base),
    .sel_o   (sel_o)
  );

  burst_order_mux #(.LO_W(CNT_W)) u_mux (
    .order_i (order),
    .start_i (base[CNT_W-1:0]),
    .cnt_i   (cnt),
    .lo_o    (lo)
  );

  assign addr_o = {base[ADDR_W-1:CNT_W], lo};

  AST_CTRL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_stb_ni |=> addr_o[ADDR_W-1:CNT_W] == $past(addr_i[ADDR_W-1:CNT_W])); // R2
  AST_CTRL_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_stb_ni |=> sel_o == $past(~ce1_ni & ce2_i & ~ce3_ni)); // R2
  AST_PROC_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_stb_ni && !proc_stb_ni && !ce1_ni && ce2_i && !ce3_ni) |=> sel_o); // R3
  AST_PROC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_stb_ni && !(!ce1_ni && ce2_i && !ce3_ni))
      |=> $stable(addr_o[ADDR_W-1:CNT_W]) && $stable(sel_o)); // R4
  AST_LOAD_OVER_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load, inc})); // R5
  AST_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_ni && ctrl_stb_ni && proc_stb_ni) |=> $stable(addr_o[ADDR_W-1:CNT_W])); // R8

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed the burst count width");
  end
endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ctrl_n = 1'b1, proc_n = 1'b1, adv_n = 1'b1;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          order = 1'b0;
  logic [AW-1:0] addr_o;
  logic          sel_o;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_sel = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i),
    .ctrl_stb_ni(ctrl_n), .proc_stb_ni(proc_n), .adv_ni(adv_n),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .order_i(order),
    .addr_o(addr_o), .sel_o(sel_o)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = order ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string req);
    vectors++;
    if (addr_o !== exp_addr() || sel_o !== m_sel) begin
      errors++;
      $display("FAIL %s: addr=%h sel=%b expected addr=%h sel=%b",
               req, addr_o, sel_o, exp_addr(), m_sel);
    end
  endtask

  // one edge; inputs set at a falling edge, model updated per requirements
  task automatic cyc(input logic c, input logic p, input logic a,
                     input logic [2:0] ce, input logic [AW-1:0] ad);
    logic ok;
    ctrl_n = c; proc_n = p; adv_n = a;
    ce1_n = ce[0]; ce2 = ce[1]; ce3_n = ce[2]; addr_i = ad;
    ok = !ce[0] && ce[1] && !ce[2];
    if (!c) begin m_base = ad; m_cnt = 0; m_sel = ok; end
    else if (!p && ok) begin m_base = ad; m_cnt = 0; m_sel = 1'b1; end
    else if (!a) m_cnt = m_cnt + 2'd1;
    @(negedge clk);
  endtask

  localparam logic [2:0] CE_ON = 3'b010;

  initial begin
    logic [AW-3:0] ups [3];
    ups[0] = '0; ups[1] = '1; ups[2] = {(AW-2)/2{2'b10}};
    @(negedge clk);
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    cyc(1, 1, 1, CE_ON, '1);
    check("R1");

    // order x start x upper pattern, advance through two wraps
    for (int o = 0; o < 2; o++)
      for (int u = 0; u < 3; u++)
        for (int s = 0; s < 4; s++) begin
          order = o[0];
          cyc(0, 1, 1, CE_ON, {ups[u], s[1:0]});
          check("R2");
          for (int k = 0; k < 8; k++) begin
            cyc(1, 1, 0, CE_ON, ~{ups[u], s[1:0]});
            check(o ? "R7 R9 R8" : "R6 R9 R8");
          end
          cyc(1, 1, 1, CE_ON, '0);
          check("R10");
          cyc(1, 1, 0, CE_ON, '0);
          order = ~order;
          #1 check("R11");
          order = o[0];
          #1 check("R11");
        end

    // chip-enable combinations under each strobe
    order = 1'b0;
    for (int e = 0; e < 8; e++)
      for (int a = 0; a < 2; a++) begin
        cyc(0, 1, 1, CE_ON, 21'h0AAA1);
        cyc(1, 1, 0, CE_ON, '0);
        cyc(0, 1, a[0], e[2:0], 21'h15552 ^ AW'(e));
        check("R2 R5");
        cyc(0, 1, 1, CE_ON, 21'h0AAA1);
        cyc(1, 1, 0, CE_ON, '0);
        cyc(1, 0, a[0], e[2:0], 21'h13333 ^ AW'(e));
        check(e[2:0] == CE_ON ? "R3 R5" : "R4");
      end

    // both strobes low with enables off: controller load wins, deselects
    cyc(1, 0, 1, CE_ON, 21'h00007);
    cyc(0, 0, 0, 3'b001, 21'h1FFF2);
    check("R2 R5");
    cyc(1, 0, 0, 3'b000, 21'h00000);
    check("R4");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule